// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block produces one peripheral clock from a parent clock. Both clocks are carried as enable qualifiers in the parent clock domain. The input `src_ce_i` marks the parent clock's active cycles. The output `div_ce_o` is a one-cycle pulse once every D of those cycles, where D is decoded from a programmable divisor field. A bit in a separate enable register gates the output pulse off and on. The period counter keeps running while the output is gated.

Software reaches three word-addressed registers over a simple single-cycle register bus:

- a status register at word address 0;
- the divisor register at word address 1;
- the enable register at word address 2.

A divisor change is never applied in the middle of an output period. The new value is held pending until the current period finishes. The busy indication stays up while the value is pending, and for a fixed number of parent cycles after the switch. Software polls busy before a write and again after it. A divisor write made while busy is set has no effect.

Top module: `gated_clk_divider`

## Requirements
- R1: After reset the divisor register reads 0, the enable register reads 0, the status register reads 0 and `div_ce_o` stays low.
- R2: With a divisor field value N, where 1 ≤ N < 2^DIV_W (and bit 5 clear when DIV_W is 6), `div_ce_o` pulses once every N `src_ce_i` pulses. Each output pulse appears one cycle after a cycle in which `src_ce_i` was high.
- R3: A divisor field of 0 divides by 2^DIV_W, which is 32 with the default DIV_W of 5.
- R4: With DIV_W = 6 and bit 5 of the field set, the division ratio is 64 times bits 4:0. When bits 4:0 are zero the ratio is 64, the same as field value 0.
- R5: With a divisor of 1, every `src_ce_i` pulse reappears on `div_ce_o` exactly one cycle later.
- R6: While enable bit EN_BIT (default bit 2) is 0, `div_ce_o` stays low. The period counter keeps counting, so the period seen after re-enabling is the programmed one.
- R7: The enable register stores and returns all DATA_W bits written to it. Software therefore changes the gating bit with a read-modify-write and leaves the other bits as they were.
- R8: While busy, a read of the status register returns 0x18 (bits 3 and 4 both set). Otherwise it returns 0.
- R9: An accepted divisor write makes status busy from the next cycle on. Busy remains set until the new divisor takes effect, and for HOLD_CYC parent cycles after that (default 4).
- R10: A new divisor takes effect only at the end of the output period in progress. That period completes at the old ratio.
- R11: A divisor write while busy is ignored. The divisor register keeps the last accepted value, and the output period does not change.
- R12: Read data appears on `bus_rdata_o` on the cycle after `bus_rd_i`. An unmapped address reads 0. The divisor register keeps and returns only its low DIV_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ce_i | input | 1 | Parent clock enable qualifier |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, registered |
| div_ce_o | output | 1 | Divided, gated clock enable pulse |

## Verification
The bench checks the boundary decodings:

- Field value 0 must give the maximum ratio. A design that treats it literally would divide by zero or by one.
- In the 6-bit build, 0x20 must give 64. A naive multiply would turn 0x20 into 0, and a wrong scale would miss the exact ratio of 128 for 0x22.
- Divide-by-1 must give one output pulse for every input pulse, with no missed or misaligned pulses.

For timing of updates, the bench writes a new divisor early in a long period and checks that the next period still has the old length. A design that switches at once would show a short period. The bench also checks that status reads busy just after the switch. It writes a different divisor while busy and checks that the register and the period ignore it.

For gating, the bench clears the enable bit while keeping its neighbouring bits set. It checks that pulses stop and that the register reads back the other bits unchanged.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  // word addresses on the register bus
  localparam int REG_STAT = 0;
  localparam int REG_DIV  = 1;
  localparam int REG_EN   = 2;

  // status bit positions that software polls (both show busy)
  localparam int BUSY_LO = 3;
  localparam int BUSY_HI = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } upd_state_t;

endpackage

// File: rtl/cdiv_decode.sv
module cdiv_decode #(
  parameter int DIV_W = 5,
  parameter int CNT_W = 6
) (
  input  logic [DIV_W-1:0] field_i,
  output logic [CNT_W-1:0] ratio_o
);

  generate
    if (DIV_W == 6) begin : g_wide
      // bit 5 scales the low five bits by 64; a zero result means maximum
      logic [CNT_W-1:0] raw;
      always_comb begin
        if (field_i[5]) raw = CNT_W'({field_i[4:0], 6'b000000});
        else            raw = CNT_W'(field_i);
        if (raw == '0)  ratio_o = CNT_W'(64);
        else            ratio_o = raw;
      end
    end else begin : g_plain
      always_comb begin
        if (field_i == '0) ratio_o = CNT_W'(1 << DIV_W);
        else               ratio_o = CNT_W'(field_i);
      end
    end
  endgenerate

endmodule

// File: rtl/cdiv_period.sv
module cdiv_period #(
  parameter int CNT_W     = 6,
  parameter int RESET_DIV = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_ce_i,
  input  logic             gate_on_i,
  input  logic             upd_req_i,
  input  logic [CNT_W-1:0] new_ratio_i,
  output logic             upd_done_o,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_q;
  logic             last;
  logic             tick_q;

  assign last       = (cnt_q == act_q - CNT_W'(1));
  // the switch point is the final parent pulse of an output period
  assign upd_done_o = src_ce_i && last && upd_req_i;
  assign tick_o     = tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      act_q  <= CNT_W'(RESET_DIV);
      tick_q <= 1'b0;
    end else begin
      tick_q <= src_ce_i && last && gate_on_i;
      if (src_ce_i) begin
        if (last) begin
          cnt_q <= '0;
          if (upd_req_i) act_q <= new_ratio_i;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int DIV_W    = 5,
  parameter int EN_BIT   = 2,
  parameter int HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [DIV_W-1:0]  div_field_o,
  output logic              gate_on_o,
  output logic              upd_req_o,
  input  logic              upd_done_i,
  output logic              busy_o
);

  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  upd_state_t        st_q;
  logic [HOLD_W-1:0] hold_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              hit_stat, hit_div, hit_en;

  assign hit_stat = (bus_addr_i == ADDR_W'(REG_STAT));
  assign hit_div  = (bus_addr_i == ADDR_W'(REG_DIV));
  assign hit_en   = (bus_addr_i == ADDR_W'(REG_EN));

  assign busy_o      = (st_q != ST_IDLE);
  assign upd_req_o   = (st_q == ST_WAIT);
  assign div_field_o = div_q;
  assign gate_on_o   = en_q[EN_BIT];
  assign bus_rdata_o = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
      div_q  <= '0;
      en_q   <= '0;
    end else begin
      if (bus_wr_i && hit_en) en_q <= bus_wdata_i;
      case (st_q)
        ST_IDLE: begin
          if (bus_wr_i && hit_div) begin
            div_q <= bus_wdata_i[DIV_W-1:0];
            st_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (upd_done_i) begin
            st_q   <= ST_HOLD;
            hold_q <= HOLD_W'(HOLD_CYC - 1);
          end
        end
        ST_HOLD: begin
          if (hold_q == '0) st_q <= ST_IDLE;
          else              hold_q <= hold_q - HOLD_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_stat) begin
      rd_mux[BUSY_LO] = busy_o;
      rd_mux[BUSY_HI] = busy_o;
    end else if (hit_div) begin
      rd_mux[DIV_W-1:0] = div_q;
    end else if (hit_en) begin
      rd_mux = en_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

endmodule

// File: rtl/gated_clk_divider.sv
module gated_clk_divider #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int DIV_W    = 5,
  parameter int EN_BIT   = 2,
  parameter int HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_ce_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              div_ce_o
);

  localparam int ZERO_DIV = 1 << DIV_W;
  localparam int MAX_DIV  = (DIV_W == 6) ? 64 * 31 : ZERO_DIV;
  localparam int CNT_W    = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] div_field;
  logic [CNT_W-1:0] ratio;
  logic             gate_on;
  logic             upd_req;
  logic             upd_done;
  logic             busy;

  cdiv_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .DIV_W   (DIV_W),
    .EN_BIT  (EN_BIT),
    .HOLD_CYC(HOLD_CYC)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_addr_i (bus_addr_i),
    .bus_wr_i   (bus_wr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .div_field_o(div_field),
    .gate_on_o  (gate_on),
    .upd_req_o  (upd_req),
    .upd_done_i (upd_done),
    .busy_o     (busy)
  );

  cdiv_decode #(
    .DIV_W(DIV_W),
    .CNT_W(CNT_W)
  ) u_decode (
    .field_i(div_field),
    .ratio_o(ratio)
  );

  cdiv_period #(
    .CNT_W    (CNT_W),
    .RESET_DIV(ZERO_DIV)
  ) u_period (
    .clk        (clk),
    .rst        (rst),
    .src_ce_i   (src_ce_i),
    .gate_on_i  (gate_on),
    .upd_req_i  (upd_req),
    .new_ratio_i(ratio),
    .upd_done_o (upd_done),
    .tick_o     (div_ce_o)
  );

endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              src_ce_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [1:0]        busy_bits,
  input logic              div_ce_o,
  input logic [DIV_W-1:0]  div_field,
  input logic              gate_on,
  input logic              busy,
  input logic              upd_done
);

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == ADDR_W'(1) && !busy) |=> busy); // R9

  AST_BUSY_AFTER_SWITCH: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> busy); // R9

  AST_FIELD_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(div_field)); // R11

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (rst)
    div_ce_o |-> $past(gate_on)); // R6

  AST_TICK_FROM_SRC: assert property (@(posedge clk) disable iff (rst)
    div_ce_o |-> $past(src_ce_i)); // R2

  AST_STATUS_PAIR: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == ADDR_W'(0)) |=> (busy_bits[0] == busy_bits[1])); // R8

endmodule

bind gated_clk_divider cdiv_checker #(
  .ADDR_W(ADDR_W),
  .DIV_W (DIV_W)
) u_cdiv_chk (
  .clk       (clk),
  .rst       (rst),
  .src_ce_i  (src_ce_i),
  .bus_addr_i(bus_addr_i),
  .bus_wr_i  (bus_wr_i),
  .bus_rd_i  (bus_rd_i),
  .busy_bits (bus_rdata_o[4:3]),
  .div_ce_o  (div_ce_o),
  .div_field (div_field),
  .gate_on   (gate_on),
  .busy      (busy),
  .upd_done  (upd_done)
);

// File: tb/gated_clk_divider_bench.sv
`timescale 1ns/1ps
module gated_clk_divider_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        src_ce = 1'b0;
  logic        bsel = 1'b0;
  logic [3:0]  baddr = '0;
  logic        bwr = 1'b0;
  logic        brd = 1'b0;
  logic [31:0] bwdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        ce_a, ce_b;

  int checks = 0;
  int errors = 0;
  int src_mode = 0;
  int src_phase = 0;
  bit src_prev = 1'b0;
  int since_a = 0, since_b = 0;
  int per_a = 0, per_b = 0;
  int ticks_a = 0, ticks_b = 0;
  int src_total = 0;
  int misalign = 0;

  always #2 clk = ~clk;

  gated_clk_divider u_gated_clk_divider (
    .clk(clk), .rst(rst), .src_ce_i(src_ce),
    .bus_addr_i(baddr), .bus_wr_i(bwr & ~bsel), .bus_rd_i(brd & ~bsel),
    .bus_wdata_i(bwdata), .bus_rdata_o(rdata_a), .div_ce_o(ce_a)
  );

  gated_clk_divider #(.DIV_W(6)) u_gated_clk_divider_w6 (
    .clk(clk), .rst(rst), .src_ce_i(src_ce),
    .bus_addr_i(baddr), .bus_wr_i(bwr & bsel), .bus_rd_i(brd & bsel),
    .bus_wdata_i(bwdata), .bus_rdata_o(rdata_b), .div_ce_o(ce_b)
  );

  // observe the results of the previous edge, then drive the next src_ce
  always @(negedge clk) begin
    if (!rst) begin
      if (src_prev) begin
        since_a++; since_b++; src_total++;
      end
      if (ce_a) begin
        if (!src_prev) misalign++;
        per_a = since_a; since_a = 0; ticks_a++;
      end
      if (ce_b) begin
        if (!src_prev) misalign++;
        per_b = since_b; since_b = 0; ticks_b++;
      end
    end
    src_phase = (src_phase == 2) ? 0 : src_phase + 1;
    src_ce = (src_mode == 0) ? 1'b1 : (src_phase == 0);
    src_prev = src_ce;
  end

  task automatic check_eq(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic bus_write(bit sel, int a, logic [31:0] d);
    @(negedge clk);
    bsel = sel; baddr = 4'(a); bwdata = d; bwr = 1'b1;
    @(negedge clk);
    bwr = 1'b0;
  endtask

  task automatic bus_read(bit sel, int a, output logic [31:0] d);
    @(negedge clk);
    bsel = sel; baddr = 4'(a); brd = 1'b1;
    @(negedge clk);
    brd = 1'b0;
    d = sel ? rdata_b : rdata_a;
  endtask

  task automatic wait_idle(bit sel);
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_read(sel, 0, s);
      if (s == 0) return;
    end
    check_eq("R9 busy never cleared", s, 0);
  endtask

  task automatic wait_ticks(bit sel, int n);
    int target;
    target = (sel ? ticks_b : ticks_a) + n;
    for (int i = 0; i < 4000; i++) begin
      if ((sel ? ticks_b : ticks_a) >= target) return;
      @(negedge clk);
    end
    check_eq("R2 output pulses missing", sel ? ticks_b : ticks_a, target);
  endtask

  task automatic program_div(bit sel, logic [31:0] v);
    wait_idle(sel);
    bus_write(sel, 1, v);
    wait_idle(sel);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(0, 1, d); check_eq("R1 divisor after reset", d, 0);
    bus_read(0, 2, d); check_eq("R1 enable after reset", d, 0);
    bus_read(0, 0, d); check_eq("R1 status after reset", d, 0);
    repeat (80) @(negedge clk);
    check_eq("R1 no output while gated after reset", ticks_a, 0);
    bus_write(0, 2, 32'h4);
    bus_write(1, 2, 32'h4);
  endtask

  task automatic t_zero_max();
    src_mode = 0;
    wait_ticks(0, 2);
    check_eq("R3 field 0 divides by 32", per_a, 32);
  endtask

  task automatic t_divide_n();
    src_mode = 1;
    program_div(0, 5);
    wait_ticks(0, 3);
    check_eq("R2 divide by 5 with sparse src", per_a, 5);
    src_mode = 0;
    program_div(0, 13);
    wait_ticks(0, 3);
    check_eq("R2 divide by 13", per_a, 13);
    check_eq("R2 pulses aligned to src", misalign, 0);
  endtask

  task automatic t_div1();
    int t0, s0;
    src_mode = 1;
    program_div(0, 1);
    wait_ticks(0, 3);
    t0 = ticks_a; s0 = src_total;
    repeat (60) @(negedge clk);
    check_eq("R5 one output per src pulse", ticks_a - t0, src_total - s0);
    check_eq("R5 period 1", per_a, 1);
    check_eq("R5 alignment", misalign, 0);
  endtask

  task automatic t_update_timing();
    logic [31:0] d;
    src_mode = 0;
    program_div(0, 0);
    wait_ticks(0, 1);
    repeat (6) @(negedge clk);
    bus_write(0, 1, 4);
    bus_read(0, 0, d); check_eq("R8 R9 busy after accepted write", d, 32'h18);
    bus_write(0, 1, 9);
    bus_read(0, 1, d); check_eq("R11 ignored write keeps value", d, 4);
    wait_ticks(0, 1);
    bus_read(0, 0, d); check_eq("R9 busy held past switch", d, 32'h18);
    check_eq("R10 period in progress keeps old ratio", per_a, 32);
    wait_ticks(0, 1);
    check_eq("R10 next period uses new ratio", per_a, 4);
    wait_idle(0);
    wait_ticks(0, 2);
    check_eq("R11 ignored write has no effect on period", per_a, 4);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    int t0;
    bus_write(0, 2, 32'hA5A5_0000);
    bus_read(0, 2, d); check_eq("R7 enable readback with gate off", d, 32'hA5A5_0000);
    @(negedge clk);
    t0 = ticks_a;
    repeat (80) @(negedge clk);
    check_eq("R6 no pulses while gated", ticks_a - t0, 0);
    bus_write(0, 2, 32'hA5A5_0004);
    bus_read(0, 2, d); check_eq("R7 enable readback with gate on", d, 32'hA5A5_0004);
    wait_ticks(0, 2);
    check_eq("R6 period after re-enable", per_a, 4);
  endtask

  task automatic t_bus_edges();
    logic [31:0] d;
    bus_read(0, 3, d); check_eq("R12 unmapped address reads 0", d, 0);
    program_div(0, 32'hFFFF_FFE7);
    bus_read(0, 1, d); check_eq("R12 divisor keeps low bits only", d, 7);
    wait_ticks(0, 2);
    check_eq("R12 masked divisor period", per_a, 7);
  endtask

  task automatic t_wide();
    logic [31:0] d;
    src_mode = 0;
    wait_ticks(1, 2);
    check_eq("R4 wide build field 0 divides by 64", per_b, 64);
    program_div(1, 32'h21);
    wait_ticks(1, 2);
    check_eq("R4 field 0x21 divides by 64", per_b, 64);
    program_div(1, 32'h22);
    bus_read(1, 1, d); check_eq("R4 wide readback", d, 32'h22);
    wait_ticks(1, 2);
    check_eq("R4 field 0x22 divides by 128", per_b, 128);
    program_div(1, 32'h20);
    wait_ticks(1, 2);
    check_eq("R4 field 0x20 divides by 64", per_b, 64);
    program_div(1, 32'h03);
    wait_ticks(1, 2);
    check_eq("R4 field 3 divides by 3", per_b, 3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zero_max();
    t_divide_n();
    t_div1();
    t_update_timing();
    t_gate();
    t_bus_edges();
    t_wide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule